// File: doc/BRIEF.md
# Precondition and Deadline Event Monitor

This block watches a stream of one-bit event strobes, at most one meaningful event per clock, and flags breaches of two interaction rules. The first rule guards a trigger event: a trigger is legal only once an enabling pattern has completed. Depending on a mode input, one completion either licenses all later triggers or licenses only the next one. The second rule is a response deadline: every completion of the enabling pattern opens a window, and a completion of the response pattern must arrive within a fixed number of cycles.

The patterns themselves are recognised elsewhere, for example by sequence checkers, which hand this block one-cycle completion strobes. The monitor reports each breach as a one-cycle violation pulse and keeps a sticky error flag that only reset clears. Both outputs are registered, so a breach caused by the events of cycle k shows on the outputs after the clock edge that ends cycle k.

Top module: `seq_guard`

## Requirements
- R1: A trigger strobe in a cycle where no enabling completion has been seen since reset (or, in repeat mode, since the last trigger) produces a violation pulse on `viol_o` after the edge that ends that cycle.
- R2: With `repeat_i` = 1, each trigger consumes the licence; a second trigger with no new enabling completion in between is a violation.
- R3: With `repeat_i` = 0, a single enabling completion licenses every later trigger, and triggers do not consume it.
- R4: A response completion arriving 1 to DEADLINE cycles after the cycle of the enabling completion closes the window without a violation.
- R5: If no response completion has arrived by the DEADLINE-th cycle after the enabling completion, a violation is reported at the end of that DEADLINE-th cycle without waiting for the response, and the window closes.
- R6: An enabling completion while a window is open, without a response completion in the same cycle, is a violation; the new completion opens a fresh window counted from its own cycle.
- R7: `viol_o` is high for exactly the cycles following offending cycles; `err_o` rises with the first violation and stays high until reset.
- R8: A response completion while no window is open has no effect on either output.
- R9: In one cycle, a trigger is judged on the licence held before that cycle; an enabling completion in the same cycle grants a licence for later triggers, also in repeat mode. A response completion in the same cycle as an enabling completion closes the old window before the new one opens.
- R10: While and after reset, `viol_o` and `err_o` are low, no licence is held and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_done_i | input | 1 | One-cycle strobe: the enabling pattern completed |
| resp_done_i | input | 1 | One-cycle strobe: the response pattern completed |
| trig_i | input | 1 | One-cycle strobe: the guarded trigger event |
| repeat_i | input | 1 | 1: each trigger needs its own enabling completion; 0: one completion licenses all |
| viol_o | output | 1 | Registered one-cycle violation pulse |
| err_o | output | 1 | Registered sticky error flag |

## Verification
The bench builds the monitor with DEADLINE = 6, so the window edge, the timeout firing without a response, and a response landing on the very last permitted cycle are all reached within a handful of cycles, and random traffic crosses the deadline boundary often. Mode flips between repeat and non-repeat in the random phase let licence consumption interleave with window overlaps and same-cycle event pairs.

// File: rtl/seq_guard_pkg.sv
package seq_guard_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  typedef struct packed {
    logic pre;
    logic resp;
    logic trig;
  } ev_t;

endpackage

// File: rtl/seq_guard_satcnt.sv
module seq_guard_satcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_one) begin
      count <= ONE;
    end else if (inc && count != MAXV) begin
      count <= count + ONE;
    end
  end

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_one && count == MAXV) |=> count == MAXV);
endmodule

// File: rtl/seq_guard_gate.sv
module seq_guard_gate
  import seq_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ev_t  ev,
  input  logic repeat_mode,
  output logic bad_trig
);
  logic licence_q;
  logic licence_d;

  assign bad_trig = ev.trig && !licence_q;

  always_comb begin
    licence_d = licence_q;
    if (ev.trig && repeat_mode) licence_d = 1'b0;
    if (ev.pre) licence_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) licence_q <= 1'b0;
    else     licence_q <= licence_d;
  end

  assert_consume_R2: assert property (@(posedge clk) disable iff (rst)
    (ev.trig && repeat_mode && !ev.pre) |=> !licence_q);
  assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (licence_q && !repeat_mode) |=> licence_q);
  assert_grant_R9: assert property (@(posedge clk) disable iff (rst)
    ev.pre |=> licence_q);
endmodule

// File: rtl/seq_guard_window.sv
module seq_guard_window
  import seq_guard_pkg::*;
#(
  parameter int DEADLINE = 12,
  parameter int CNT_W    = $clog2(DEADLINE + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  ev_t  ev,
  output logic expired,
  output logic overlap
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEADLINE);

  win_state_e      state_q;
  win_state_e      state_d;
  logic [CNT_W-1:0] elapsed;
  logic            open_w;

  assign open_w  = (state_q == WIN_OPEN);
  assign expired = open_w && !ev.resp && (elapsed == LIMIT);
  assign overlap = open_w && ev.pre && !ev.resp && !expired;

  always_comb begin
    state_d = state_q;
    if (ev.pre)                    state_d = WIN_OPEN;
    else if (ev.resp || expired)   state_d = WIN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= WIN_IDLE;
    else     state_q <= state_d;
  end

  seq_guard_satcnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_one (ev.pre),
    .inc      (open_w),
    .count    (elapsed)
  );

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
    open_w |-> (elapsed >= 1 && elapsed <= LIMIT));
  assert_close_on_resp_R4: assert property (@(posedge clk) disable iff (rst)
    (open_w && ev.resp && !ev.pre) |=> state_q == WIN_IDLE);
  assert_close_on_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (expired && !ev.pre) |=> state_q == WIN_IDLE);
  assert_idle_resp_R8: assert property (@(posedge clk) disable iff (rst)
    (!open_w && ev.resp && !ev.pre) |=> state_q == WIN_IDLE);
endmodule

// File: rtl/seq_guard.sv
module seq_guard
  import seq_guard_pkg::*;
#(
  parameter int DEADLINE = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic pre_done_i,
  input  logic resp_done_i,
  input  logic trig_i,
  input  logic repeat_i,
  output logic viol_o,
  output logic err_o
);
  ev_t  ev;
  logic bad_trig;
  logic expired;
  logic overlap;
  logic breach;

  assign ev.pre  = pre_done_i;
  assign ev.resp = resp_done_i;
  assign ev.trig = trig_i;

  seq_guard_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .repeat_mode (repeat_i),
    .bad_trig    (bad_trig)
  );

  seq_guard_window #(.DEADLINE(DEADLINE)) u_win (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .expired (expired),
    .overlap (overlap)
  );

  assign breach = bad_trig | expired | overlap;

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      viol_o <= breach;
      err_o  <= err_o | breach;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  assert_pulse_sets_err_R7: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> err_o);
  assert_bad_trig_R1: assert property (@(posedge clk) disable iff (rst)
    bad_trig |=> viol_o);
endmodule

// File: tb/sim_seq_guard.sv
module sim_seq_guard;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pre = 1'b0, resp = 1'b0, trig = 1'b0, rep = 1'b0;
  logic viol, err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit m_lic, m_open, m_err;
  int m_el;

  always #4 clk = ~clk;

  seq_guard #(.DEADLINE(T)) u0 (
    .clk(clk), .rst(rst), .pre_done_i(pre), .resp_done_i(resp),
    .trig_i(trig), .repeat_i(rep), .viol_o(viol), .err_o(err)
  );

  function automatic bit exp_viol(bit p, bit q, bit tr);
    bit v = 1'b0;
    if (tr && !m_lic) v = 1'b1;
    if (m_open && !q && m_el == T) v = 1'b1;
    if (m_open && p && !q) v = 1'b1;
    return v;
  endfunction

  task automatic advance_model(bit p, bit q, bit tr, bit r, bit v);
    if (tr && r) m_lic = 1'b0;
    if (p) m_lic = 1'b1;
    if (p) begin
      m_open = 1'b1; m_el = 1;
    end else if (m_open) begin
      if (q || m_el == T) m_open = 1'b0;
      else m_el++;
    end
    m_err = m_err | v;
  endtask

  task automatic check(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pre = 0; resp = 0; trig = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R10", viol, 1'b0, "viol in reset");
    check("R10", err, 1'b0, "err in reset");
    @(negedge clk);
    rst = 1'b0;
    m_lic = 0; m_open = 0; m_err = 0; m_el = 0;
  endtask

  task automatic step(bit p, bit q, bit tr, bit r, string tag);
    bit v;
    @(negedge clk);
    pre = p; resp = q; trig = tr; rep = r;
    v = exp_viol(p, q, tr);
    advance_model(p, q, tr, r, v);
    @(posedge clk);
    #1;
    check(tag, viol, v, "viol");
    check(tag, err, m_err, "err");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: trigger with no licence
    step(0, 0, 1, 1, "R1");
    check("R1", viol, 1'b1, "unlicensed trigger");
    do_reset();
    // R2: repeat mode consumes licence
    step(1, 0, 0, 1, "R2");
    step(0, 1, 0, 1, "R2");
    step(0, 0, 1, 1, "R2");
    check("R2", viol, 1'b0, "first trigger legal");
    step(0, 0, 1, 1, "R2");
    check("R2", viol, 1'b1, "second trigger needs new licence");
    do_reset();
    // R3: single licence covers all triggers
    step(1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, "R3");
    check("R3", err, 1'b0, "no error after many triggers");
    do_reset();
    // R4: response on the last permitted cycle
    step(1, 0, 0, 0, "R4");
    for (int k = 0; k < T - 1; k++) step(0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, "R4");
    check("R4", viol, 1'b0, "response at deadline");
    check("R4", err, 1'b0, "no error");
    do_reset();
    // R5 then R8: timeout without response, then late response ignored
    step(1, 0, 0, 0, "R5");
    for (int k = 0; k < T - 1; k++) step(0, 0, 0, 0, "R5");
    check("R5", viol, 1'b0, "not yet expired");
    step(0, 0, 0, 0, "R5");
    check("R5", viol, 1'b1, "expiry flagged");
    step(0, 1, 0, 0, "R8");
    check("R8", viol, 1'b0, "late response ignored");
    // R7: sticky flag, single pulse
    step(0, 0, 0, 0, "R7");
    check("R7", err, 1'b1, "err sticky");
    check("R7", viol, 1'b0, "pulse ended");
    do_reset();
    // R6: overlapping enabling completion
    step(1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    check("R6", viol, 1'b1, "overlap");
    for (int k = 0; k < T - 1; k++) step(0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, "R6");
    check("R6", viol, 1'b0, "fresh window from second completion");
    do_reset();
    // R9: same-cycle orderings
    step(1, 0, 1, 1, "R9");
    check("R9", viol, 1'b1, "trigger judged on old licence");
    step(0, 1, 1, 1, "R9");
    check("R9", viol, 1'b0, "licence granted by same-cycle completion");
    step(1, 0, 0, 1, "R9");
    step(1, 1, 0, 1, "R9");
    check("R9", viol, 1'b0, "response closes old window first");
    do_reset();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit p = ($urandom % 6) == 0;
      bit q = ($urandom % 5) == 0;
      bit tr = ($urandom % 6) == 0;
      bit r = ((n / 200) % 2) == 0;
      step(p, q, tr, r, r ? "R2" : "R3");
      if (($urandom % 500) == 0) do_reset();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule